// File: doc/BRIEF.md
# SMT Entry Allocation Gate

This block decides, every cycle, whether each of two hardware threads may claim a batch of entries in one shared out-of-order structure, such as a reorder buffer or a scheduler. It keeps a running occupancy count per thread. Each thread presents an allocate request with a count and a release count. The block returns a grant per thread in the same cycle. The entries and their payload live elsewhere. Only the counting and granting logic is built here.

The sharing rule between the threads can be selected at run time: an even split, a programmable per-thread ceiling, or a free-for-all. A thread that runs alone may always fill the whole structure. When a second thread is enabled, the block stops all allocation until the occupancy already held fits the two-thread limits. Only then does it let both threads allocate. When both threads fit on their own but not together, an alternating pointer decides which one is granted.

Top module: `smt_alloc_gate`

## Requirements
- R1: After reset both occupancies are zero, both grants are low and `draining_o` is low.
- R2: A thread is granted only when all of these hold: the thread is enabled, it requests, no drain is in progress, its post-release occupancy plus its count is at most its limit, and its count is at most the free entries (total minus both post-release occupancies). Partial grants never occur. The grant is combinational in the request cycle, and occupancy at the next edge equals occupancy minus release plus any granted count.
- R3: With `policy_i` = 0 (even split) and both threads settled, each thread's limit is N/2.
- R4: With `policy_i` = 1 (ceiling) and both threads settled, each thread's limit is the smaller of `watermark_i` and N.
- R5: With `policy_i` = 2 or 3 (shared) and both threads settled, each thread's limit is N.
- R6: While only one thread is enabled (`thread_en_i` = 01 or 10), that thread's limit is N under every policy. A disabled thread is never granted.
- R7: When `thread_en_i` becomes 11 from any other value, `draining_o` goes high and neither thread is granted. Draining ends after the first cycle in which both post-release occupancies are at most the two-thread limit. Two-thread limits apply from the following cycle. If either thread is disabled, the two-thread state is left at the next edge.
- R8: When both threads fit individually but their counts together exceed the free entries, exactly one is granted. The pointer starts at thread 0 after reset, and after every such contested cycle it moves to the thread that lost.
- R9: Releases are subtracted before grants are judged in the same cycle. A release larger than the thread's occupancy is an error, and occupancy never goes below zero.
- R10: The sum of both occupancies never exceeds N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_en_i | input | 2 | Per-thread enable; bit t enables thread t |
| policy_i | input | 2 | 0 even split, 1 ceiling, 2 or 3 shared |
| watermark_i | input | OCC_W | Per-thread ceiling for policy 1 |
| alloc_req_i | input | 2 | Per-thread allocate request |
| alloc_cnt_i | input | 2*CNT_W | Entries requested; thread 0 in the low CNT_W bits |
| release_cnt_i | input | 2*CNT_W | Entries freed this cycle; thread 0 in the low CNT_W bits |
| alloc_gnt_o | output | 2 | Per-thread grant, same cycle as the request |
| occ_o | output | 2*OCC_W | Registered occupancy; thread 0 in the low OCC_W bits |
| draining_o | output | 1 | High while the second-thread drain is in progress |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is release and grant. The bench releases entries from a full structure in the same cycle that both threads request, so a grant is only possible because of that release. In the same setup the two requests fit individually but not together, which provokes contested arbitration; the bench repeats this so the winner must alternate. The second pair is drain completion and release. The bench enables the second thread while thread 0 holds every entry, then releases in steps. It expects `draining_o` to stay high through the cycle in which the release brings occupancy under the split, and the first grant one cycle later. A behavioural model using plain integers is compared against the grants, occupancies and drain flag on every cycle of these directed phases and of a long random phase.

// File: rtl/smt_alloc_pkg.sv
package smt_alloc_pkg;
  typedef enum logic [1:0] {
    POL_SPLIT   = 2'd0,
    POL_CEIL    = 2'd1,
    POL_SHARED  = 2'd2,
    POL_SHARED2 = 2'd3
  } policy_e;
endpackage

// File: rtl/smt_occ_counter.sv
module smt_occ_counter #(
  parameter int OCC_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             gnt_i,
  output logic [OCC_W-1:0] occ_o,
  output logic [OCC_W-1:0] post_o
);
  logic [OCC_W-1:0] occ_q, rel_ext, add_ext;

  assign rel_ext = OCC_W'(rel_i);
  assign add_ext = gnt_i ? OCC_W'(cnt_i) : '0;
  // saturate; over-release is flagged by the checker
  assign post_o  = (rel_ext > occ_q) ? '0 : occ_q - rel_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= post_o + add_ext;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/smt_limit_calc.sv
module smt_limit_calc
  import smt_alloc_pkg::*;
#(
  parameter int N_ENTRIES = 48,
  parameter int OCC_W     = 6
) (
  input  logic [1:0]       policy_i,
  input  logic [OCC_W-1:0] watermark_i,
  input  logic             settled_i,
  output logic [OCC_W-1:0] dual_lim_o,
  output logic [OCC_W-1:0] lim_o
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(N_ENTRIES);
  localparam logic [OCC_W-1:0] HALF = OCC_W'(N_ENTRIES / 2);

  always_comb begin
    case (policy_e'(policy_i))
      POL_SPLIT: dual_lim_o = HALF;
      POL_CEIL:  dual_lim_o = (watermark_i > FULL) ? FULL : watermark_i;
      default:   dual_lim_o = FULL;
    endcase
  end

  assign lim_o = settled_i ? dual_lim_o : FULL;
endmodule

// File: rtl/smt_grant_arb.sv
module smt_grant_arb #(
  parameter int N_ENTRIES = 48,
  parameter int OCC_W     = 6,
  parameter int CNT_W     = 4
) (
  input  logic [1:0][OCC_W-1:0] post_i,
  input  logic [1:0][CNT_W-1:0] cnt_i,
  input  logic [OCC_W-1:0]      lim_i,
  input  logic [1:0]            req_i,
  input  logic                  rr_i,
  output logic [1:0]            gnt_o,
  output logic                  contested_o
);
  localparam int SUM_W = OCC_W + 2;

  logic [SUM_W-1:0] free_ent, pair_cnt;
  logic [1:0]       fit;

  assign free_ent = SUM_W'(N_ENTRIES) - SUM_W'(post_i[0]) - SUM_W'(post_i[1]);
  assign pair_cnt = SUM_W'(cnt_i[0]) + SUM_W'(cnt_i[1]);

  for (genvar t = 0; t < 2; t++) begin : g_fit
    assign fit[t] = req_i[t]
                 && (SUM_W'(post_i[t]) + SUM_W'(cnt_i[t]) <= SUM_W'(lim_i))
                 && (SUM_W'(cnt_i[t]) <= free_ent);
  end

  assign contested_o = (&fit) && (pair_cnt > free_ent);
  assign gnt_o       = contested_o ? (rr_i ? 2'b10 : 2'b01) : fit;
endmodule

// File: rtl/smt_alloc_gate.sv
module smt_alloc_gate #(
  parameter  int N_ENTRIES = 48,
  parameter  int MAX_REQ   = 8,
  localparam int OCC_W     = $clog2(N_ENTRIES + 1),
  localparam int CNT_W     = $clog2(MAX_REQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         thread_en_i,
  input  logic [1:0]         policy_i,
  input  logic [OCC_W-1:0]   watermark_i,
  input  logic [1:0]         alloc_req_i,
  input  logic [2*CNT_W-1:0] alloc_cnt_i,
  input  logic [2*CNT_W-1:0] release_cnt_i,
  output logic [1:0]         alloc_gnt_o,
  output logic [2*OCC_W-1:0] occ_o,
  output logic               draining_o
);
  logic [1:0][CNT_W-1:0] cnt, rel;
  logic [1:0][OCC_W-1:0] occ, post;
  logic [OCC_W-1:0]      lim, dual_lim;
  logic [1:0]            gnt, req_ok;
  logic                  dual_q, rr_q, en_both, draining, drain_done, contested;

  assign cnt      = alloc_cnt_i;
  assign rel      = release_cnt_i;
  assign en_both  = &thread_en_i;
  assign draining = en_both & ~dual_q;
  assign req_ok   = alloc_req_i & thread_en_i & {2{~draining}};

  smt_limit_calc #(.N_ENTRIES(N_ENTRIES), .OCC_W(OCC_W)) u_lim (
    .policy_i    (policy_i),
    .watermark_i (watermark_i),
    .settled_i   (en_both & dual_q),
    .dual_lim_o  (dual_lim),
    .lim_o       (lim)
  );

  for (genvar t = 0; t < 2; t++) begin : g_thr
    smt_occ_counter #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rel_i  (rel[t]),
      .cnt_i  (cnt[t]),
      .gnt_i  (gnt[t]),
      .occ_o  (occ[t]),
      .post_o (post[t])
    );
  end

  smt_grant_arb #(.N_ENTRIES(N_ENTRIES), .OCC_W(OCC_W), .CNT_W(CNT_W)) u_arb (
    .post_i      (post),
    .cnt_i       (cnt),
    .lim_i       (lim),
    .req_i       (req_ok),
    .rr_i        (rr_q),
    .gnt_o       (gnt),
    .contested_o (contested)
  );

  assign drain_done = (post[0] <= dual_lim) && (post[1] <= dual_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dual_q <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      dual_q <= en_both & (dual_q | drain_done);
      if (contested) rr_q <= ~rr_q;
    end
  end

  assign alloc_gnt_o = gnt;
  assign occ_o       = occ;
  assign draining_o  = draining;
endmodule

// File: rtl/smt_alloc_gate_chk.sv
module smt_alloc_gate_chk #(
  parameter int N_ENTRIES = 48,
  parameter int OCC_W     = 6,
  parameter int CNT_W     = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         thread_en_i,
  input logic [1:0]         policy_i,
  input logic [OCC_W-1:0]   watermark_i,
  input logic [1:0]         alloc_req_i,
  input logic [2*CNT_W-1:0] release_cnt_i,
  input logic [1:0]         alloc_gnt_o,
  input logic [2*OCC_W-1:0] occ_o,
  input logic               draining_o
);
  localparam int SUM_W = OCC_W + 1;
  logic [OCC_W-1:0] o0, o1;
  assign o0 = occ_o[OCC_W-1:0];
  assign o1 = occ_o[2*OCC_W-1:OCC_W];

  a_r10_total_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SUM_W'(o0) + SUM_W'(o1)) <= SUM_W'(N_ENTRIES));

  a_r7_drain_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draining_o |-> (alloc_gnt_o == 2'b00));

  a_r6_gnt_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_gnt_o & ~(thread_en_i & alloc_req_i)) == 2'b00);

  a_r9_release_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OCC_W'(release_cnt_i[CNT_W-1:0]) <= o0) && (OCC_W'(release_cnt_i[2*CNT_W-1:CNT_W]) <= o1));

  a_r3_split_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd0 && thread_en_i == 2'b11 && alloc_gnt_o[1]) |=> o1 <= OCC_W'(N_ENTRIES / 2));

  a_r4_ceil_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd1 && thread_en_i == 2'b11 && alloc_gnt_o[0]) |=> o0 <= $past(watermark_i));

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_gnt_o == 2'b00 && release_cnt_i == '0) |=> $stable(occ_o));
endmodule

bind smt_alloc_gate smt_alloc_gate_chk #(
  .N_ENTRIES (N_ENTRIES),
  .OCC_W     (OCC_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .thread_en_i   (thread_en_i),
  .policy_i      (policy_i),
  .watermark_i   (watermark_i),
  .alloc_req_i   (alloc_req_i),
  .release_cnt_i (release_cnt_i),
  .alloc_gnt_o   (alloc_gnt_o),
  .occ_o         (occ_o),
  .draining_o    (draining_o)
);

// File: tb/smt_alloc_gate_test.sv
module smt_alloc_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 48;
  localparam int OW = 6;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] en = '0, pol = '0, req = '0;
  logic [OW-1:0] wm = '0;
  logic [2*CW-1:0] cnt_v = '0, rel_v = '0;
  logic [1:0] gnt;
  logic [2*OW-1:0] occ;
  logic drn;

  int n_chk = 0, n_fail = 0;
  int m_occ[2];
  bit m_dual = 0, m_rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_alloc_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .thread_en_i(en), .policy_i(pol),
    .watermark_i(wm), .alloc_req_i(req), .alloc_cnt_i(cnt_v),
    .release_cnt_i(rel_v), .alloc_gnt_o(gnt), .occ_o(occ), .draining_o(drn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] e, input int p, input int w, input logic [1:0] rq,
                      input int c0, input int c1, input int r0, input int r1);
    int c[2], r[2], post[2], dlim, lim, fr;
    bit eb, dr, st, cont;
    bit fit[2], g[2];
    string tg;
    @(negedge clk);
    chk(int'(occ[OW-1:0]) == m_occ[0], "R2 occ0", int'(occ[OW-1:0]), m_occ[0]);
    chk(int'(occ[2*OW-1:OW]) == m_occ[1], "R2 occ1", int'(occ[2*OW-1:OW]), m_occ[1]);
    chk(int'(occ[OW-1:0]) + int'(occ[2*OW-1:OW]) <= N, "R10 total",
        int'(occ[OW-1:0]) + int'(occ[2*OW-1:OW]), N);
    c[0] = c0; c[1] = c1;
    r[0] = (r0 > m_occ[0]) ? m_occ[0] : r0;
    r[1] = (r1 > m_occ[1]) ? m_occ[1] : r1;
    en = e; pol = p[1:0]; wm = w[OW-1:0]; req = rq;
    cnt_v = {c[1][CW-1:0], c[0][CW-1:0]};
    rel_v = {r[1][CW-1:0], r[0][CW-1:0]};
    #1;
    eb = (e == 2'b11);
    dr = eb && !m_dual;
    st = eb && m_dual;
    dlim = (p == 0) ? N/2 : (p == 1) ? ((w > N) ? N : w) : N;
    lim = st ? dlim : N;
    for (int t = 0; t < 2; t++) post[t] = m_occ[t] - r[t];
    fr = N - post[0] - post[1];
    for (int t = 0; t < 2; t++)
      fit[t] = e[t] && rq[t] && !dr && (post[t] + c[t] <= lim) && (c[t] <= fr);
    cont = fit[0] && fit[1] && (c[0] + c[1] > fr);
    g = fit;
    if (cont) begin g[0] = !m_rr; g[1] = m_rr; end
    chk(drn == dr, "R7 draining", int'(drn), int'(dr));
    for (int t = 0; t < 2; t++) begin
      if (cont) tg = "R8";
      else if (dr) tg = "R7";
      else if (!e[t]) tg = "R6";
      else if (r[0] + r[1] > 0) tg = "R9";
      else if (!st) tg = "R6";
      else tg = (p == 0) ? "R3" : (p == 1) ? "R4" : "R5";
      chk(gnt[t] == g[t], $sformatf("%s gnt%0d", tg, t), int'(gnt[t]), int'(g[t]));
    end
    if (cont) m_rr = !m_rr;
    m_dual = eb && (m_dual || (post[0] <= dlim && post[1] <= dlim));
    for (int t = 0; t < 2; t++) m_occ[t] = post[t] + (g[t] ? c[t] : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_occ[0] = 0; m_occ[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(occ == '0, "R1 occ", int'(occ), 0);
    chk(gnt == 2'b00, "R1 gnt", int'(gnt), 0);
    chk(drn == 1'b0, "R1 drain", int'(drn), 0);
    // one thread fills everything even under the split policy
    for (int i = 0; i < 7; i++) step(2'b01, 0, 30, 2'b11, 8, 8, 0, 0);
    // second thread enabled: drain with stepped releases
    for (int i = 0; i < 7; i++) step(2'b11, 0, 30, 2'b11, 1, 2, 5, 0);
    for (int i = 0; i < 5; i++) step(2'b11, 0, 30, 2'b10, 0, 8, 0, 0);
    for (int i = 0; i < 3; i++) step(2'b11, 0, 30, 2'b01, 1, 0, 0, 0);
    // shared: fill, then release + contested requests in one cycle
    for (int i = 0; i < 4; i++) step(2'b11, 2, 30, 2'b11, 8, 8, 0, 0);
    for (int i = 0; i < 8; i++) step(2'b11, 2, 30, 2'b11, 4, 4, (i % 2) ? 0 : 4, (i % 2) ? 4 : 0);
    for (int i = 0; i < 6; i++) step(2'b11, 3, 30, 2'b11, 3, 3, 0, 0);
    // ceiling
    for (int i = 0; i < 10; i++) step(2'b11, 1, 30, 2'b11, 5, 5, 6, 6);
    for (int i = 0; i < 6; i++) step(2'b11, 1, 30, 2'b11, 7, 7, 0, 0);
    // drop back to one thread, then re-enable
    for (int i = 0; i < 4; i++) step(2'b10, 0, 30, 2'b11, 8, 8, 0, 2);
    for (int i = 0; i < 8; i++) step(2'b11, 0, 30, 2'b11, 2, 2, 0, 6);
    // random phase
    begin
      logic [1:0] re = 2'b11;
      int rp = 0, rw = 30;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(19) == 0) re = 2'($urandom_range(2) + 1);
        if ($urandom_range(29) == 0) rp = $urandom_range(3);
        if ($urandom_range(29) == 0) rw = $urandom_range(63);
        step(re, rp, rw, 2'($urandom_range(3)), $urandom_range(8), $urandom_range(8),
             $urandom_range(8), $urandom_range(8));
      end
    end
    step(2'b01, 0, 30, 2'b00, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule